// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block tells the rest of the chip whether a phase-locked loop has settled. For each phase-detector cycle it receives two single-cycle pulses, one for the reference edge and one for the feedback edge. Both are already synchronised to a fast sampling clock. The block counts sampling-clock cycles from whichever edge comes first to the one that follows, and uses that count as the phase error of the cycle.

Lock is acquired only after a run of consecutive small-error cycles. The run length is 3 or 5, chosen by a mode input. Once the flag is set, only a large error clears it. The band between the two thresholds is tolerated, which gives the flag hysteresis so that it does not chatter at the edge of lock. If the trailing edge never arrives, the cycle is given up after a timeout and counted as a large error.

Top module: `lock_detector`

## Requirements
- R1: While reset (`rst_n` low) is held, and in the cycle after it is released, `locked` is 0.
- R2: With `long_run` = 0, `locked` rises at the clock edge that completes the third consecutive cycle whose error is below `ACQ_THR`. With the default `ACQ_THR` of 3, the accepted errors are 0, 1 and 2.
- R3: With `long_run` = 1, five consecutive such cycles are needed, and four are not enough.
- R4: While locked, one cycle whose error exceeds `LOSE_THR` (default 5, so 6 or more) clears `locked` at the edge that completes that cycle.
- R5: While locked, errors from `ACQ_THR` up to `LOSE_THR` inclusive leave `locked` high.
- R6: While unlocked, any cycle with error at or above `ACQ_THR` restarts the count of good cycles from zero.
- R7: The error is the number of sampling-clock edges from the leading pulse to the trailing pulse, whichever of the two inputs leads. Pulses in the same cycle mean an error of 0.
- R8: If the trailing pulse has not arrived when the count reaches `TIMEOUT` (default 12), the cycle ends and is treated as an error above `LOSE_THR`.
- R9: Reset clears both `locked` and the good-cycle count, so a partial run made before reset does not count afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse on each reference edge |
| fb_edge | input | 1 | One-cycle pulse on each feedback edge |
| long_run | input | 1 | 0: three good cycles to lock, 1: five |
| locked | output | 1 | Active-high lock indication |

## Verification
The bench aims at the threshold boundaries: errors of exactly 2, 3, 5 and 6 counts. A design with an off-by-one compare would either lock on a marginal error or drop lock inside the tolerated band. It also checks a run that is one cycle short in each mode and a run broken by a single marginal cycle, which catch a counter that saturates wrongly or is never cleared. A lagging reference edge, a missing trailing edge and a reset part-way through a run show up a design that measures only one edge order, waits forever for the second edge, or keeps stale run progress.

// File: rtl/lock_detector.sv
module lock_detector #(
  parameter int ACQ_THR   = 3,
  parameter int LOSE_THR  = 5,
  parameter int TIMEOUT   = 12,
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic long_run,
  output logic locked
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(RUN_LONG + 1);

  logic          waiting, lead_ref;
  logic [CW-1:0] cnt;
  logic [RW-1:0] run, need;
  logic          trail, expired, done, good, bad;
  logic [CW-1:0] err;

  assign trail   = lead_ref ? fb_edge : ref_edge;
  assign expired = waiting && !trail && (cnt == CW'(TIMEOUT));
  assign done    = waiting ? (trail || expired) : (ref_edge && fb_edge);
  assign err     = waiting ? cnt : '0;
  assign good    = done && !expired && (int'(err) < ACQ_THR);
  assign bad     = done && (expired || int'(err) > LOSE_THR);
  assign need    = long_run ? RW'(RUN_LONG) : RW'(RUN_SHORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      lead_ref <= 1'b0;
      cnt      <= '0;
    end else if (!waiting) begin
      if (ref_edge ^ fb_edge) begin
        waiting  <= 1'b1;
        lead_ref <= ref_edge;
        cnt      <= CW'(1);
      end
    end else if (done) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (done) begin
      if (locked) begin
        if (bad) locked <= 1'b0;
        run <= '0;
      end else if (good) begin
        if (run + 1'b1 >= need) begin
          locked <= 1'b1;
          run    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

  a_r2_r3_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(good) && ($past(run) + 1 >= $past(need))));
  a_r4_r8_fall_needs_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bad));
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && done && !bad) |=> locked);
  a_r6_bad_cycle_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && done && !good) |=> (run == '0 && !locked));
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= TIMEOUT);
  a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run) < RUN_LONG);
  a_r1_quiet_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(locked));
endmodule

// File: tb/tb_lock_detector.sv
`timescale 1ns/1ps
module tb_lock_detector;
  logic clk = 1'b0, rst_n = 1'b0, ref_edge = 1'b0, fb_edge = 1'b0, long_run = 1'b0;
  logic locked;
  int   vectors = 0, misses = 0;
  bit   finished = 1'b0;
  string cur_req = "R1";

  int pend = 0, el = 0, run_m = 0;
  bit lock_m = 1'b0;

  lock_detector dut (.clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
                     .long_run(long_run), .locked(locked));

  always #2.5 clk = ~clk;

  task automatic model(input logic r, input logic f);
    bit fin = 0, tmo = 0;
    int e = 0, need;
    if (!rst_n) begin
      pend = 0; el = 0; run_m = 0; lock_m = 0;
      return;
    end
    if (pend == 0) begin
      if (r && f) begin fin = 1; e = 0; end
      else if (r) begin pend = 1; el = 1; end
      else if (f) begin pend = 2; el = 1; end
    end else begin
      if ((pend == 1) ? f : r) begin fin = 1; e = el; pend = 0; end
      else if (el == 12) begin fin = 1; tmo = 1; pend = 0; end
      else el++;
    end
    if (!fin) return;
    need = long_run ? 5 : 3;
    if (lock_m) begin
      if (tmo || e > 5) lock_m = 0;
      run_m = 0;
    end else if (!tmo && e < 3) begin
      run_m++;
      if (run_m >= need) begin lock_m = 1; run_m = 0; end
    end else run_m = 0;
  endtask

  task automatic step(input logic r, input logic f);
    @(negedge clk);
    ref_edge = r; fb_edge = f;
    model(r, f);
    @(posedge clk); #1;
    vectors++;
    if (locked !== lock_m) begin
      misses++;
      $display("FAIL %s: locked=%b expected %b at %0t", cur_req, locked, lock_m, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic pd(input int off, input bit ref_leads);
    if (off == 0) step(1, 1);
    else begin
      step(ref_leads, !ref_leads);
      idle(off - 1);
      step(!ref_leads, ref_leads);
    end
    idle(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    cur_req = "R1"; do_reset();
    cur_req = "R2"; long_run = 0;
    pd(2, 1); pd(0, 1); pd(1, 1);
    cur_req = "R5"; pd(3, 1); pd(4, 1); pd(5, 1); pd(5, 0);
    cur_req = "R4"; pd(6, 1);
    cur_req = "R3"; long_run = 1;
    pd(1, 1); pd(2, 1); pd(0, 1); pd(1, 1); pd(2, 1);
    cur_req = "R4"; pd(9, 0);
    cur_req = "R6"; long_run = 0;
    pd(1, 1); pd(1, 1); pd(3, 1); pd(1, 1); pd(1, 1); pd(2, 1);
    cur_req = "R7"; pd(6, 0); pd(2, 0); pd(1, 0); pd(0, 0); pd(2, 0);
    cur_req = "R8"; step(1, 0); idle(16); pd(1, 0);
    step(0, 1); idle(16);
    cur_req = "R9"; pd(1, 1); pd(1, 1); do_reset(); pd(1, 1); pd(1, 1); pd(1, 1);
    do_reset(); pd(0, 1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule